// File: doc/BRIEF.md
# Binarized XOR-Popcount Neuron Engine

This block evaluates one neuron of a fully connected layer in which both the inputs and the weights are restricted to the values +1 and -1. Each value is stored as one bit. The block takes pairs of 32-bit words over a valid/ready input. One word holds 32 activations and the other holds the matching 32 weights. Equal bits contribute +1 and differing bits contribute -1. As a result, the dot product of one word pair equals the number of counted lanes minus twice the population count of their XOR. No multiplier is needed.

A start pulse loads the number of words in the fan-in and the number of valid lanes in the final word, and it clears the running sum. The engine then accepts exactly that many word pairs and adds each pair's signed contribution to a 16-bit accumulator. After the last pair it presents the signed sum and a single activation bit. The activation bit is 1 only when the sum is strictly positive. The result is held until the consumer takes it. A fan-in of 100 needs four words, with 4 valid lanes in the last word. A fan-in of 1 needs one word with a single valid lane.

Top module: `bnn_neuron_engine`

## Requirements
- R1: Lane i of a word is bit i; bit value 1 encodes +1 and 0 encodes -1. A full word pair adds 32 − 2·popcount(act XOR wgt) to the sum.
- R2: A start pulse in the idle state with a nonzero word count clears the sum and latches the word count and the last-word lane count. A start with word count 0 is ignored. A start while a neuron is in progress or a result is pending is also ignored.
- R3: `in_ready_o` is high only while words are being accepted. Exactly the latched number of word pairs is taken per neuron.
- R4: In the last word only lanes below the last-word lane count k are counted, so that word adds k − 2·popcount of the masked XOR. Bits at lane k and above have no effect. A lane count of 0 or above 32 means a full word.
- R5: `res_valid_o` rises in the cycle after the handshake of the last word. It stays high with sum and bit unchanged until a cycle with `res_ready_i` high. In the following cycle it is low.
- R6: `res_bit_o` is 1 when the sum is greater than zero. It is 0 when the sum is zero or negative.
- R7: `res_sum_o` is the exact two's-complement sum in 16 bits, covering the full range ±32·255 reachable with an 8-bit word count.
- R8: While a result is pending, `in_ready_o` is low.
- R9: Cycles with `in_valid_i` low during accumulation add nothing and do not count as words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new neuron |
| num_words_i | input | 8 | Number of word pairs in the fan-in |
| last_valid_i | input | 6 | Valid lanes in the final word (0 = full) |
| act_i | input | 32 | Packed activation word |
| wgt_i | input | 32 | Packed weight word |
| in_valid_i | input | 1 | Word pair present |
| in_ready_o | output | 1 | Engine accepts a word pair |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_bit_o | output | 1 | Sign activation (1 = +1) |
| res_sum_o | output | 16 | Signed accumulated dot product |

## Verification
The sum and the activation bit come straight from the accumulator register. Both are therefore due one clock after the handshake of the final word, in the same cycle that `res_valid_o` rises. The bench changes inputs on the falling edge and samples outputs on the next falling edge. Each result check therefore sits exactly one rising edge after the last handshake. The same spacing is used to check that `res_valid_o` drops one edge after acceptance, and that an ignored start leaves `in_ready_o` low on the next sample.

// File: rtl/bnn_pkg.sv
package bnn_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_DONE  = 2'd2
   } eng_state_e;

endpackage

// File: rtl/bnn_word_dot.sv
module bnn_word_dot #(
   parameter int WORD_W   = 32,
   parameter int SUM_W    = 16,
   parameter bit POP_TREE = 1'b1,
   parameter int LANE_W   = $clog2(WORD_W + 1)
) (
   input  logic [WORD_W-1:0]       act_i,
   input  logic [WORD_W-1:0]       wgt_i,
   input  logic [LANE_W-1:0]       keep_i,
   output logic signed [SUM_W-1:0] contrib_o
);

   localparam int PAD = SUM_W - LANE_W;

   logic [WORD_W-1:0] lane_mask;
   logic [WORD_W-1:0] diff;
   logic [LANE_W-1:0] pop_sum;

   initial begin : prm_chk
      assert (PAD >= 2) else $error("SUM_W too narrow for lane count");
      assert (!POP_TREE || ((WORD_W & (WORD_W - 1)) == 0))
         else $error("tree popcount needs a power-of-two word");
   end

   always_comb begin
      for (int i = 0; i < WORD_W; i++) begin
         lane_mask[i] = (LANE_W'(i) < keep_i);
      end
   end

   assign diff = (act_i ^ wgt_i) & lane_mask;

   generate
      if (POP_TREE) begin : g_tree
         logic [LANE_W-1:0] node [1:2*WORD_W-1];
         for (genvar g = 0; g < WORD_W; g++) begin : g_leaf
            assign node[WORD_W+g] = LANE_W'(diff[g]);
         end
         for (genvar g = 1; g < WORD_W; g++) begin : g_node
            assign node[g] = node[2*g] + node[2*g+1];
         end
         assign pop_sum = node[1];
      end else begin : g_chain
         always_comb begin
            pop_sum = '0;
            for (int i = 0; i < WORD_W; i++) begin
               pop_sum = pop_sum + LANE_W'(diff[i]);
            end
         end
      end
   endgenerate

   assign contrib_o = $signed({{PAD{1'b0}}, keep_i})
                    - $signed({{(PAD-1){1'b0}}, pop_sum, 1'b0});

endmodule

// File: rtl/bnn_accum.sv
module bnn_accum #(
   parameter int SUM_W    = 16,
   parameter int STEP_MAX = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    add_i,
   input  logic signed [SUM_W-1:0] val_i,
   output logic signed [SUM_W-1:0] acc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (clr_i) begin
         acc_o <= '0;
      end else if (add_i) begin
         acc_o <= acc_o + val_i;
      end
   end

   // R1
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !clr_i) |=>
         ((int'(acc_o) - int'($past(acc_o)) <= STEP_MAX) &&
          (int'(acc_o) - int'($past(acc_o)) >= -STEP_MAX)));

endmodule

// File: rtl/bnn_ctrl.sv
module bnn_ctrl
   import bnn_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 8,
   parameter int LANE_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  num_words_i,
   input  logic [LANE_W-1:0] last_valid_i,
   input  logic              in_valid_i,
   input  logic              res_ready_i,
   output logic              in_ready_o,
   output logic              res_valid_o,
   output logic              clr_o,
   output logic              add_o,
   output logic [LANE_W-1:0] keep_o
);

   localparam logic [LANE_W-1:0] FULL_K = LANE_W'(WORD_W);

   eng_state_e        state;
   logic [CNT_W-1:0]  remain;
   logic [LANE_W-1:0] last_k;
   logic [LANE_W-1:0] k_norm;

   assign k_norm = ((last_valid_i == '0) || (last_valid_i > FULL_K)) ? FULL_K : last_valid_i;

   assign clr_o       = (state == ST_IDLE) && start_i && (num_words_i != '0);
   assign in_ready_o  = (state == ST_ACCUM);
   assign add_o       = in_ready_o && in_valid_i;
   assign res_valid_o = (state == ST_DONE);
   assign keep_o      = (remain == CNT_W'(1)) ? last_k : FULL_K;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         remain <= '0;
         last_k <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (clr_o) begin
                  state  <= ST_ACCUM;
                  remain <= num_words_i;
                  last_k <= k_norm;
               end
            end
            ST_ACCUM: begin
               if (in_valid_i) begin
                  remain <= remain - 1'b1;
                  if (remain == CNT_W'(1)) state <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (res_ready_i) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [CNT_W-1:0] hs_cnt;
   logic [CNT_W-1:0] hs_tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_cnt <= '0;
         hs_tgt <= '0;
      end else if (clr_o) begin
         hs_cnt <= '0;
         hs_tgt <= num_words_i;
      end else if (add_o) begin
         hs_cnt <= hs_cnt + 1'b1;
      end
   end

   // R3
   word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid_o) |-> (hs_cnt == hs_tgt));

   // R8
   ready_low_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> !in_ready_o);

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> res_valid_o);

endmodule

// File: rtl/bnn_neuron_engine.sv
module bnn_neuron_engine #(
   parameter int WORD_W   = 32,
   parameter int SUM_W    = 16,
   parameter int CNT_W    = 8,
   parameter bit POP_TREE = 1'b1,
   parameter int LANE_W   = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  num_words_i,
   input  logic [LANE_W-1:0] last_valid_i,
   input  logic [WORD_W-1:0] act_i,
   input  logic [WORD_W-1:0] wgt_i,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   output logic              res_valid_o,
   input  logic              res_ready_i,
   output logic              res_bit_o,
   output logic [SUM_W-1:0]  res_sum_o
);

   localparam longint MAX_MAG = longint'(WORD_W) * ((longint'(1) << CNT_W) - 1);

   initial begin : prm_chk
      assert (MAX_MAG < (longint'(1) << (SUM_W - 1)))
         else $error("SUM_W cannot hold the largest fan-in sum");
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
   end

   logic                    clr;
   logic                    add;
   logic [LANE_W-1:0]       keep;
   logic signed [SUM_W-1:0] contrib;
   logic signed [SUM_W-1:0] acc;

   bnn_ctrl #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W),
      .LANE_W (LANE_W)
   ) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .num_words_i  (num_words_i),
      .last_valid_i (last_valid_i),
      .in_valid_i   (in_valid_i),
      .res_ready_i  (res_ready_i),
      .in_ready_o   (in_ready_o),
      .res_valid_o  (res_valid_o),
      .clr_o        (clr),
      .add_o        (add),
      .keep_o       (keep)
   );

   bnn_word_dot #(
      .WORD_W   (WORD_W),
      .SUM_W    (SUM_W),
      .POP_TREE (POP_TREE),
      .LANE_W   (LANE_W)
   ) i_dot (
      .act_i     (act_i),
      .wgt_i     (wgt_i),
      .keep_i    (keep),
      .contrib_o (contrib)
   );

   bnn_accum #(
      .SUM_W    (SUM_W),
      .STEP_MAX (WORD_W)
   ) i_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .add_i (add),
      .val_i (contrib),
      .acc_o (acc)
   );

   assign res_sum_o = acc;
   assign res_bit_o = (acc > 0);

   // R5
   sum_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> ($stable(res_sum_o) && $stable(res_bit_o)));

   // R4
   contrib_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add |-> ((int'(contrib) <= int'(keep)) && (int'(contrib) >= -int'(keep))));

   // R2
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (res_sum_o == '0) && in_ready_o);

endmodule

// File: tb/test_bnn_neuron_engine.sv
module test_bnn_neuron_engine;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  num_words_i = '0;
   logic [5:0]  last_valid_i = '0;
   logic [31:0] act_i = '0;
   logic [31:0] wgt_i = '0;
   logic        in_valid_i = 1'b0;
   logic        in_ready_o;
   logic        res_valid_o;
   logic        res_ready_i = 1'b0;
   logic        res_bit_o;
   logic [15:0] res_sum_o;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bnn_neuron_engine i_bnn_neuron_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .num_words_i  (num_words_i),
      .last_valid_i (last_valid_i),
      .act_i        (act_i),
      .wgt_i        (wgt_i),
      .in_valid_i   (in_valid_i),
      .in_ready_o   (in_ready_o),
      .res_valid_o  (res_valid_o),
      .res_ready_i  (res_ready_i),
      .res_bit_o    (res_bit_o),
      .res_sum_o    (res_sum_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int word_model(input logic [31:0] a, input logic [31:0] w, input int k);
      int s = 0;
      for (int j = 0; j < k; j++) s += (a[j] == w[j]) ? 1 : -1;
      return s;
   endfunction

   // Check the pending result, then accept it after hold cycles.
   task automatic finish_result(input string tag, input int exp, input int hold);
      chk({tag, " R5 valid"}, int'(res_valid_o), 1);
      chk({tag, " R8 ready low"}, int'(in_ready_o), 0);
      chk({tag, " R7 sum"}, int'($signed(res_sum_o)), exp);
      chk({tag, " R6 bit"}, int'(res_bit_o), (exp > 0) ? 1 : 0);
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk({tag, " R5 held"}, int'(res_valid_o), 1);
         chk({tag, " R5 sum stable"}, int'($signed(res_sum_o)), exp);
      end
      res_ready_i = 1'b1;
      @(negedge clk);
      res_ready_i = 1'b0;
      chk({tag, " R5 drop"}, int'(res_valid_o), 0);
   endtask

   // pat: 0 random, 1 weights equal activations, 2 weights inverted
   task automatic run_case(input string tag, input int nw, input int lv,
                           input int pat, input int gap, input int hold);
      int exp = 0;
      int kk = (lv == 0 || lv > 32) ? 32 : lv;
      @(negedge clk);
      start_i = 1'b1; num_words_i = 8'(nw); last_valid_i = 6'(lv);
      @(negedge clk);
      start_i = 1'b0;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] a = $urandom;
         logic [31:0] b = (pat == 1) ? a : (pat == 2) ? ~a : $urandom;
         for (int g = 0; g < gap; g++) begin
            in_valid_i = 1'b0;
            @(negedge clk);
         end
         act_i = a; wgt_i = b; in_valid_i = 1'b1;
         exp += word_model(a, b, (w == nw - 1) ? kk : 32);
         if (w == 0 || w == nw - 1) chk({tag, " R3 ready"}, int'(in_ready_o), 1);
         @(negedge clk);
      end
      in_valid_i = 1'b0;
      finish_result(tag, exp, hold);
   endtask

   task automatic run_word(input string tag, input int lv, input logic [31:0] a,
                           input logic [31:0] w, input int exp);
      @(negedge clk);
      start_i = 1'b1; num_words_i = 8'd1; last_valid_i = 6'(lv);
      @(negedge clk);
      start_i = 1'b0; act_i = a; wgt_i = w; in_valid_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0;
      finish_result(tag, exp, 0);
   endtask

   task automatic test_reset();
      chk("R5 reset valid", int'(res_valid_o), 0);
      chk("R3 reset ready", int'(in_ready_o), 0);
      chk("R7 reset sum", int'($signed(res_sum_o)), 0);
   endtask

   task automatic test_start_ignored();
      logic [31:0] a0 = $urandom, w0 = $urandom, a1 = $urandom, w1 = $urandom;
      int exp = word_model(a0, w0, 32) + word_model(a1, w1, 32);
      @(negedge clk);
      start_i = 1'b1; num_words_i = 8'd0; last_valid_i = 6'd0;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 zero count ignored", int'(in_ready_o), 0);
      start_i = 1'b1; num_words_i = 8'd2;
      @(negedge clk);
      act_i = a0; wgt_i = w0; in_valid_i = 1'b1;
      num_words_i = 8'd5;
      @(negedge clk);
      start_i = 1'b0; act_i = a1; wgt_i = w1;
      @(negedge clk);
      in_valid_i = 1'b0;
      chk("R2 restart in accum ignored", int'(res_valid_o), 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 start while pending", int'($signed(res_sum_o)), exp);
      finish_result("R2 run", exp, 0);
      chk("R2 back to idle", int'(in_ready_o), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_case("R1 fanin32", 1, 0, 0, 0, 0);
      run_case("R1 fanin32b", 1, 32, 0, 0, 2);
      run_case("R4 fanin100", 4, 4, 0, 0, 0);
      run_case("R4 fanin100b", 4, 4, 0, 0, 1);
      run_case("R4 fanin1", 1, 1, 0, 0, 0);
      run_case("R4 fanin1b", 1, 1, 0, 0, 0);
      run_case("R9 stalls", 4, 4, 0, 2, 0);
      run_case("R7 max", 255, 0, 1, 0, 0);
      run_case("R7 min", 255, 0, 2, 0, 0);
      run_case("R4 oversize k", 2, 40, 0, 0, 0);
      run_word("R4 masked garbage", 4, 32'hA5A5_5A35, 32'h5A5A_A5A5, 4);
      run_word("R6 zero sum", 2, 32'hFFFF_FF01, 32'h0000_0003, 0);
      run_word("R6 negative", 1, 32'h0000_0001, 32'hFFFF_FFFE, -1);
      test_start_ignored();
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule